// File: doc/BRIEF.md
# Serial Receive Deframer

The deframer takes recovered serial bits, qualified by a per-bit valid strobe, and turns them into bytes for the receive datapath. A fixed 16-bit start-of-frame pattern, set by a parameter, is matched on the bit stream in arrival order. After that pattern the block passes a programmable number of header bytes, from 0 to 15. It then raises a window flag that tells downstream CRC logic which bytes to include.

Configuration inputs select several options. One complements every incoming bit. Another takes bits from a transmit-side loopback stream instead of the line. A third sets whether the first bit of each byte is its most or least significant bit, and this choice has no effect on delimiter detection. Stuffed-bit removal can be switched off, and when it is on it starts either right after the delimiter or after the header. A frame-end pulse closes the frame and sends the block back to searching for the delimiter.

Top module: `rx_deframer`

## Requirements
- R1: After reset, `byte_vld`, `sfd_hit`, `hdr_done` and `crc_win` are 0, and the block searches for the delimiter.
- R2: With `cfg_invert` = 1, each accepted input bit is complemented before detection, unstuffing and assembly.
- R3: With `cfg_loop` = 1, `lpbk_bit`/`lpbk_vld` replace `line_bit`/`line_vld` as the receive source, and line activity is ignored.
- R4: While searching, `sfd_hit` pulses for one cycle when the last 16 accepted bits, oldest first, equal the pattern 16'hF3A0. This holds for either setting of `cfg_msb_first`.
- R5: With `cfg_msb_first` = 1, the first assembled bit after the delimiter lands in `byte_out[7]`. With 0, it lands in `byte_out[0]`. Each byte is 8 kept bits, and every 8th kept bit gives a one-cycle `byte_vld`.
- R6: `hdr_done` pulses once per frame. It coincides with the `byte_vld` of header byte number `cfg_hdr_len`, or with `sfd_hit` when `cfg_hdr_len` = 0.
- R7: `crc_win` is 0 during every header byte's `byte_vld`. It is 1 during every later byte's `byte_vld` and rises one cycle after `hdr_done`.
- R8: When unstuffing is active, the bit that follows five consecutive kept 1s is discarded, and the run count restarts. With `cfg_stuff_late` = 0, unstuffing is active from the first bit after the delimiter.
- R9: With `cfg_stuff_late` = 1, header bits are never discarded, and unstuffing starts with a fresh run count at the first bit after the header.
- R10: With `cfg_stuff_en` = 0, no bit is ever discarded.
- R11: A `frame_end` pulse forces `crc_win` to 0 on the next cycle and returns to delimiter search. No `byte_vld` follows until a new delimiter is found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_bit | input | 1 | Recovered line bit |
| line_vld | input | 1 | Strobe qualifying `line_bit` |
| lpbk_bit | input | 1 | Transmit serial bit for loopback |
| lpbk_vld | input | 1 | Strobe qualifying `lpbk_bit` |
| cfg_invert | input | 1 | Complement incoming bits |
| cfg_loop | input | 1 | Receive from loopback stream |
| cfg_msb_first | input | 1 | 1: first bit is byte MSB; 0: LSB |
| cfg_hdr_len | input | 4 | Header bytes after delimiter |
| cfg_stuff_late | input | 1 | 0: unstuff after delimiter; 1: after header |
| cfg_stuff_en | input | 1 | Enable stuffed-bit removal |
| frame_end | input | 1 | Closes the frame |
| byte_out | output | 8 | Assembled byte |
| byte_vld | output | 1 | `byte_out` valid pulse |
| sfd_hit | output | 1 | Delimiter found pulse |
| hdr_done | output | 1 | Header complete pulse |
| crc_win | output | 1 | CRC gating window |

## Verification
Every frame starts with an alternating preamble and the delimiter, followed by header and payload bytes that contain 0xFF runs. Those runs only come out right if the stuffed bits are removed at the correct point. Sending the same frame with the line complemented, sent MSB-first, or fed through the loopback pins shows whether inversion, bit order and source selection are applied in the right places. Header lengths 0, 2, 3 and 15 show whether `hdr_done` and the window edge track the programmed count. The early, late and disabled unstuffing settings differ in which bits an 0xFF header byte must lose. After each `frame_end`, one extra byte is sent without a delimiter to confirm that the search state was re-entered.

// File: rtl/rxdf_pkg.sv
package rxdf_pkg;
   typedef enum logic [1:0] {
      PH_HUNT = 2'd0,
      PH_HDR  = 2'd1,
      PH_DATA = 2'd2
   } rxdf_phase_e;
endpackage

// File: rtl/rxdf_line_sel.sv
module rxdf_line_sel (
   input  logic line_bit,
   input  logic line_vld,
   input  logic lpbk_bit,
   input  logic lpbk_vld,
   input  logic cfg_loop,
   input  logic cfg_invert,
   output logic s_bit,
   output logic s_vld
);
   always_comb begin
      s_bit = (cfg_loop ? lpbk_bit : line_bit) ^ cfg_invert;
      s_vld = cfg_loop ? lpbk_vld : line_vld;
   end
endmodule

// File: rtl/rxdf_sfd_match.sv
module rxdf_sfd_match #(
   parameter int unsigned           LEN     = 16,
   parameter logic [LEN-1:0]        PATTERN = 16'hF3A0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic shift_en,
   input  logic bit_in,
   output logic hit
);
   logic [LEN-1:0] win_q;
   logic [LEN-1:0] win_d;

   if (LEN < 2) begin : g_len_chk
      $error("rxdf_sfd_match: LEN must be at least 2");
   end

   assign win_d = {win_q[LEN-2:0], bit_in};
   assign hit   = shift_en && (win_d == PATTERN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        win_q <= '0;
      else if (clr)      win_q <= '0;
      else if (shift_en) win_q <= win_d;
   end
endmodule

// File: rtl/rxdf_unstuff.sv
module rxdf_unstuff #(
   parameter int unsigned RUN_MAX = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic active,
   input  logic vld,
   input  logic bit_in,
   output logic take
);
   localparam int unsigned RUN_W = $clog2(RUN_MAX + 1);

   logic [RUN_W-1:0] run_q;
   logic             drop;

   if (RUN_MAX < 1) begin : g_run_chk
      $error("rxdf_unstuff: RUN_MAX must be at least 1");
   end

   assign drop = active && (run_q == RUN_W'(RUN_MAX));
   assign take = vld && !drop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                run_q <= '0;
      else if (restart)          run_q <= '0;
      else if (vld) begin
         if (!active || drop)    run_q <= '0;
         else if (bit_in)        run_q <= run_q + RUN_W'(1);
         else                    run_q <= '0;
      end
   end
endmodule

// File: rtl/rxdf_assemble.sv
module rxdf_assemble #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic         take,
   input  logic         bit_in,
   input  logic         msb_first,
   output logic [W-1:0] word,
   output logic         done
);
   localparam int unsigned CNT_W = $clog2(W);

   logic [W-1:0]     sh_q;
   logic [CNT_W-1:0] cnt_q;

   if (W < 2) begin : g_w_chk
      $error("rxdf_assemble: W must be at least 2");
   end

   always_comb begin
      if (msb_first) word = {sh_q[W-2:0], bit_in};
      else           word = {bit_in, sh_q[W-1:1]};
   end

   assign done = take && (cnt_q == CNT_W'(W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (take) begin
         sh_q  <= word;
         cnt_q <= done ? '0 : cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer #(
   parameter int unsigned          BYTE_W      = 8,
   parameter int unsigned          HDR_W       = 4,
   parameter int unsigned          SFD_LEN     = 16,
   parameter logic [SFD_LEN-1:0]   SFD_PATTERN = 16'hF3A0,
   parameter int unsigned          RUN_MAX     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_bit,
   input  logic              line_vld,
   input  logic              lpbk_bit,
   input  logic              lpbk_vld,
   input  logic              cfg_invert,
   input  logic              cfg_loop,
   input  logic              cfg_msb_first,
   input  logic [HDR_W-1:0]  cfg_hdr_len,
   input  logic              cfg_stuff_late,
   input  logic              cfg_stuff_en,
   input  logic              frame_end,
   output logic [BYTE_W-1:0] byte_out,
   output logic              byte_vld,
   output logic              sfd_hit,
   output logic              hdr_done,
   output logic              crc_win
);
   import rxdf_pkg::*;

   localparam int unsigned HC_W = HDR_W + 1;

   rxdf_phase_e       phase_q;
   logic [HDR_W-1:0]  hdr_cnt_q;
   logic              s_bit, s_vld;
   logic              hunt, hit, f_vld, take, asm_done, last_hdr;
   logic              stuff_on, run_restart;
   logic [BYTE_W-1:0] word;

   if (HDR_W < 1) begin : g_hdr_chk
      $error("rx_deframer: HDR_W must be at least 1");
   end

   rxdf_line_sel u_sel (
      .line_bit   (line_bit),
      .line_vld   (line_vld),
      .lpbk_bit   (lpbk_bit),
      .lpbk_vld   (lpbk_vld),
      .cfg_loop   (cfg_loop),
      .cfg_invert (cfg_invert),
      .s_bit      (s_bit),
      .s_vld      (s_vld)
   );

   assign hunt = (phase_q == PH_HUNT);

   rxdf_sfd_match #(.LEN(SFD_LEN), .PATTERN(SFD_PATTERN)) u_sfd (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (frame_end || hit),
      .shift_en (s_vld && hunt && !frame_end),
      .bit_in   (s_bit),
      .hit      (hit)
   );

   assign f_vld    = s_vld && !hunt && !frame_end;
   assign stuff_on = cfg_stuff_en &&
                     ((phase_q == PH_DATA) || ((phase_q == PH_HDR) && !cfg_stuff_late));

   rxdf_unstuff #(.RUN_MAX(RUN_MAX)) u_unstuff (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (run_restart),
      .active  (stuff_on),
      .vld     (f_vld),
      .bit_in  (s_bit),
      .take    (take)
   );

   rxdf_assemble #(.W(BYTE_W)) u_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (frame_end || hit),
      .take      (take),
      .bit_in    (s_bit),
      .msb_first (cfg_msb_first),
      .word      (word),
      .done      (asm_done)
   );

   assign last_hdr    = (phase_q == PH_HDR) && asm_done &&
                        (({1'b0, hdr_cnt_q} + HC_W'(1)) == {1'b0, cfg_hdr_len});
   assign run_restart = frame_end || hit || (last_hdr && cfg_stuff_late);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_HUNT;
         hdr_cnt_q <= '0;
      end else if (frame_end) begin
         phase_q   <= PH_HUNT;
      end else if (hit) begin
         phase_q   <= (cfg_hdr_len == '0) ? PH_DATA : PH_HDR;
         hdr_cnt_q <= '0;
      end else if ((phase_q == PH_HDR) && asm_done) begin
         hdr_cnt_q <= hdr_cnt_q + HDR_W'(1);
         if (last_hdr) phase_q <= PH_DATA;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_out <= '0;
         byte_vld <= 1'b0;
         sfd_hit  <= 1'b0;
         hdr_done <= 1'b0;
         crc_win  <= 1'b0;
      end else begin
         byte_vld <= asm_done;
         if (asm_done) byte_out <= word;
         sfd_hit  <= hit;
         hdr_done <= (hit && (cfg_hdr_len == '0)) || last_hdr;
         crc_win  <= !frame_end && (phase_q == PH_DATA);
      end
   end

   // R4: delimiter indication is a single-cycle pulse
   assert_sfd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sfd_hit |=> !sfd_hit);

   // R6: header-complete pulse is single-cycle and tied to a byte or the delimiter
   assert_hdr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_done |=> !hdr_done);
   assert_hdr_on_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_done |-> (byte_vld || sfd_hit));

   // R7: window is closed at the header edge and opens one cycle later
   assert_win_after_hdr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_done |-> !crc_win);
   assert_win_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_done && !frame_end) |=> crc_win);

   // R11: frame end closes the window
   assert_end_closes_R11: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> !crc_win);
endmodule

// File: tb/test_rx_deframer.sv
module test_rx_deframer;
   localparam logic [15:0] PAT = 16'hF3A0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_bit = 1'b0, line_vld = 1'b0;
   logic       lpbk_bit = 1'b0, lpbk_vld = 1'b0;
   logic       cfg_invert = 1'b0, cfg_loop = 1'b0, cfg_msb_first = 1'b0;
   logic [3:0] cfg_hdr_len = 4'd0;
   logic       cfg_stuff_late = 1'b0, cfg_stuff_en = 1'b0;
   logic       frame_end = 1'b0;
   logic [7:0] byte_out;
   logic       byte_vld, sfd_hit, hdr_done, crc_win;

   int n_chk = 0, n_fail = 0;
   int ncap = 0, hdr_at = -1, n_sfd = 0, n_hdr = 0, ones = 0;
   bit stuff_on = 0, finished = 0;
   logic [7:0] cap [64];
   logic       capw [64];

   always #2 clk = ~clk;

   rx_deframer i_rx_deframer (
      .clk(clk), .rst_n(rst_n),
      .line_bit(line_bit), .line_vld(line_vld),
      .lpbk_bit(lpbk_bit), .lpbk_vld(lpbk_vld),
      .cfg_invert(cfg_invert), .cfg_loop(cfg_loop), .cfg_msb_first(cfg_msb_first),
      .cfg_hdr_len(cfg_hdr_len), .cfg_stuff_late(cfg_stuff_late), .cfg_stuff_en(cfg_stuff_en),
      .frame_end(frame_end),
      .byte_out(byte_out), .byte_vld(byte_vld), .sfd_hit(sfd_hit),
      .hdr_done(hdr_done), .crc_win(crc_win)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (byte_vld && ncap < 64) begin
            cap[ncap]  = byte_out;
            capw[ncap] = crc_win;
            ncap++;
         end
         if (hdr_done) begin hdr_at = ncap; n_hdr++; end
         if (sfd_hit) n_sfd++;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put(input logic b);
      if (cfg_loop) begin lpbk_bit = b ^ cfg_invert; lpbk_vld = 1'b1; end
      else          begin line_bit = b ^ cfg_invert; line_vld = 1'b1; end
      @(posedge clk); #1;
      lpbk_vld = 1'b0; line_vld = 1'b0;
   endtask

   task automatic put_s(input logic b);
      put(b);
      if (stuff_on) begin
         ones = b ? ones + 1 : 0;
         if (ones == 5) begin put(1'b0); ones = 0; end
      end
   endtask

   task automatic put_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) put_s(cfg_msb_first ? v[7-i] : v[i]);
   endtask

   function automatic logic [7:0] hdr_byte(input int k);
      return (k == 1) ? 8'hFF : (8'h3C ^ 8'(k));
   endfunction

   function automatic logic [7:0] pay_byte(input int k);
      case (k)
         0: return 8'hFF;
         1: return 8'h7E;
         2: return 8'hA5;
         3: return 8'hFF;
         default: return 8'h01;
      endcase
   endfunction

   task automatic gap(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic run_frame(input string tag, input int hn);
      ncap = 0; hdr_at = -1; n_sfd = 0; n_hdr = 0;
      cfg_hdr_len = 4'(hn);
      stuff_on = 0;
      for (int i = 0; i < 16; i++) put(i[0]);
      for (int i = 15; i >= 0; i--) put(PAT[i]);
      ones = 0;
      stuff_on = cfg_stuff_en && !cfg_stuff_late;
      for (int k = 0; k < hn; k++) put_byte(hdr_byte(k));
      if (cfg_stuff_late) begin stuff_on = cfg_stuff_en; ones = 0; end
      for (int k = 0; k < 5; k++) put_byte(pay_byte(k));
      gap(3);
      chk({tag, " R4 delimiter pulses"}, n_sfd, 1);
      chk({tag, " R6 header pulses"}, n_hdr, 1);
      chk({tag, " R6 header position"}, hdr_at, hn);
      chk({tag, " R5 byte count"}, ncap, hn + 5);
      for (int k = 0; k < hn + 5 && k < ncap; k++) begin
         chk({tag, " R5/R8 byte value"}, cap[k], (k < hn) ? hdr_byte(k) : pay_byte(k - hn));
         chk({tag, " R7 window flag"}, capw[k], (k < hn) ? 0 : 1);
      end
      chk({tag, " R7 window open before end"}, crc_win, 1);
      frame_end = 1'b1; @(posedge clk); #1; frame_end = 1'b0;
      chk({tag, " R11 window closed"}, crc_win, 0);
      ncap = 0; stuff_on = 0;
      put_byte(8'h5A);
      gap(3);
      chk({tag, " R11 no byte after end"}, ncap, 0);
   endtask

   task automatic t_reset;
      chk("R1 byte_vld", byte_vld, 0);
      chk("R1 sfd_hit", sfd_hit, 0);
      chk("R1 hdr_done", hdr_done, 0);
      chk("R1 crc_win", crc_win, 0);
   endtask

   task automatic t_basic;
      cfg_stuff_en = 1; cfg_stuff_late = 0;
      run_frame("basic early-stuff R8", 2);
   endtask

   task automatic t_invert;
      cfg_invert = 1;
      run_frame("inverted R2", 2);
      cfg_invert = 0;
   endtask

   task automatic t_msb;
      cfg_msb_first = 1;
      run_frame("msb-first R5", 2);
      cfg_msb_first = 0;
   endtask

   task automatic t_hdr0;
      run_frame("header 0 R6", 0);
   endtask

   task automatic t_hdr15;
      run_frame("header 15 R6", 15);
   endtask

   task automatic t_late;
      cfg_stuff_late = 1;
      run_frame("late stuff R9", 3);
      cfg_stuff_late = 0;
   endtask

   task automatic t_nostuff;
      cfg_stuff_en = 0;
      run_frame("stuff off R10", 3);
      cfg_stuff_en = 1;
   endtask

   task automatic t_loop;
      cfg_loop = 1;
      run_frame("loopback R3", 2);
      cfg_loop = 0;
   endtask

   initial begin
      gap(3);
      #1 rst_n = 1'b1;
      gap(2);
      t_reset();
      t_basic();
      t_invert();
      t_msb();
      t_hdr0();
      t_hdr15();
      t_late();
      t_nostuff();
      t_loop();
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule